// File: doc/BRIEF.md
# Directional Sequence Combination Lock

This block is a synchronous finite state machine that behaves like a rotary combination lock. Each operation presented to it is a token made of a rotation direction and a dial number. The token is accepted in any clock cycle where the operation strobe is high. The lock opens only after three tokens arrive in a fixed order: right to 13, then left to 22, then right to 3. Supplying the same numbers in a different order, or with a different direction, does not open it.

Progress is held in four states. The state is reported as a two-bit code so that its path can be followed from outside. The open indicator depends only on the current state. Any accepted operation made while the lock is open closes it again. A wrong entry abandons the progress made so far. The one exception is a wrong entry that is itself the first step of the combination, which counts as a fresh start.

Top module: `dial_sequence_lock`

## Requirements
- R1: A clock edge with the active-low reset `rst_n` low puts the lock in the idle state (code 2'b00) with `lock_open` low.
- R2: In a cycle with `op_valid` low, the state code does not change at the next edge, whatever the direction and dial inputs carry.
- R3: From idle (00), a valid operation with direction right (`op_dir`=0) and dial 13 moves the state to 2'b01.
- R4: From 01, a valid operation with direction left (`op_dir`=1) and dial 22 moves the state to 2'b10.
- R5: From 10, a valid operation with direction right and dial 3 moves the state to 2'b11, and `lock_open` is high from the following cycle.
- R6: In states 00, 01 and 10, a valid operation that is not the expected next step returns the state to 00. If that operation is right-13, the state goes to 01 instead.
- R7: Only the ordered sequence opens the lock. The same three tokens in any other order, or any step given with the opposite direction, never reach state 11.
- R8: In state 11, any valid operation relocks the lock. The state goes to 00, or to 01 if the operation is right-13.
- R9: Dial values 30 and 31 match no step. A valid operation carrying either value sends the state to 00.
- R10: `lock_open` is high exactly when the state code is 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes occur on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_valid | input | 1 | High for one cycle per dial operation |
| op_dir | input | 1 | Rotation direction: 0 right, 1 left |
| op_dial | input | 5 | Dial number, unsigned |
| lock_open | output | 1 | High while the lock is open |
| state_code | output | 2 | Current state: 00 idle, 01 first step done, 10 second step done, 11 open |

## Verification
The bench targets four kinds of case. The first is a repeated right-13 while partway through the sequence; a design that reset fully here would drop to 00 instead of staying at 01. The second is a correct number given with the wrong direction; a design that ignored direction would open. The third is an operation made while the lock is open; a design without relock would stay at 11, and one that always went to idle would miss the restart to 01. The last covers out-of-range dial values, permuted orderings, idle cycles between steps, and a reset while open. Each of these would show up as a state code that differs from the bench's token-by-token model in the cycle after the operation.

// File: rtl/lock_pkg.sv
// Shared definitions for the directional sequence lock.
// Assumes a combination of exactly three steps, which the two-bit state code encodes.
package lock_pkg;
    localparam int LK_STEPS = 3;

    typedef enum logic [1:0] {
        LK_IDLE = 2'b00,
        LK_ONE  = 2'b01,
        LK_TWO  = 2'b10,
        LK_OPEN = 2'b11
    } lk_state_e;
endpackage

// File: rtl/lock_step_match.sv
// Compares one dial token against every step of the combination.
// Assumes step i direction is KEY_DIRS[i] and step i value is KEY_VALS[i*DW +: DW].
// Values above DIAL_MAX never match.
module lock_step_match
    import lock_pkg::*;
#(
    parameter int                    DW       = 5,
    parameter int                    DIAL_MAX = 29,
    parameter logic [LK_STEPS-1:0]    KEY_DIRS = 3'b010,
    parameter logic [LK_STEPS*DW-1:0] KEY_VALS = {5'd3, 5'd22, 5'd13}
) (
    input  logic                op_dir,
    input  logic [DW-1:0]       op_dial,
    output logic [LK_STEPS-1:0] step_hit
);
    localparam logic [DW-1:0] LIMIT = DW'(DIAL_MAX);

    logic in_range;

    // Qualify the dial value against the usable range.
    always_comb in_range = (op_dial <= LIMIT);

    for (genvar i = 0; i < LK_STEPS; i++) begin : g_step
        // Match direction and value for step i.
        always_comb step_hit[i] = in_range
                                && (op_dir == KEY_DIRS[i])
                                && (op_dial == KEY_VALS[i*DW +: DW]);
    end
endmodule

// File: rtl/lock_next_state.sv
// Next-state logic of the lock.
// Assumes step_hit is one bit per combination step and that step 0 is the restart token.
// Holds when no operation is valid.
module lock_next_state
    import lock_pkg::*;
(
    input  lk_state_e           cur,
    input  logic                op_valid,
    input  logic [LK_STEPS-1:0] step_hit,
    output lk_state_e           nxt
);
    lk_state_e fallback;

    // A mismatch restarts at step one when the token itself is step one.
    always_comb fallback = step_hit[0] ? LK_ONE : LK_IDLE;

    // Advance on the expected step, otherwise fall back; hold without a valid op.
    always_comb begin
        nxt = cur;
        if (op_valid) begin
            unique case (cur)
                LK_IDLE: nxt = step_hit[0] ? LK_ONE  : LK_IDLE;
                LK_ONE:  nxt = step_hit[1] ? LK_TWO  : fallback;
                LK_TWO:  nxt = step_hit[2] ? LK_OPEN : fallback;
                LK_OPEN: nxt = fallback;
                default: nxt = LK_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lock_state_reg.sv
// State register of the lock with synchronous active-low reset.
// Assumes nxt already folds in the valid strobe.
module lock_state_reg
    import lock_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  lk_state_e nxt,
    output lk_state_e cur
);
    // Capture next state, or idle under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cur <= LK_IDLE;
        else        cur <= nxt;
    end

    // R1: reset lands in idle.
    p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> cur == LK_IDLE);

    // R7: the open state is entered only from the second-step state or held.
    p_open_from_two_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cur == LK_OPEN) |-> ($past(cur) == LK_TWO || $past(cur) == LK_OPEN));
endmodule

// File: rtl/dial_sequence_lock.sv
// Directional sequence combination lock, top level.
// Assumes one token per cycle at most, qualified by op_valid, and a synchronous active-low reset.
// lock_open depends only on the current state.
module dial_sequence_lock
    import lock_pkg::*;
#(
    parameter int                    DW       = 5,
    parameter int                    DIAL_MAX = 29,
    parameter logic [LK_STEPS-1:0]    KEY_DIRS = 3'b010,
    parameter logic [LK_STEPS*DW-1:0] KEY_VALS = {5'd3, 5'd22, 5'd13}
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          op_valid,
    input  logic          op_dir,
    input  logic [DW-1:0] op_dial,
    output logic          lock_open,
    output logic [1:0]    state_code
);
    localparam logic [DW-1:0] FIRST_VAL = KEY_VALS[0 +: DW];
    localparam logic [DW-1:0] LIMIT     = DW'(DIAL_MAX);

    logic [LK_STEPS-1:0] step_hit;
    lk_state_e           cur;
    lk_state_e           nxt;

    lock_step_match #(
        .DW(DW), .DIAL_MAX(DIAL_MAX), .KEY_DIRS(KEY_DIRS), .KEY_VALS(KEY_VALS)
    ) u_match (
        .op_dir  (op_dir),
        .op_dial (op_dial),
        .step_hit(step_hit)
    );

    lock_next_state u_next (
        .cur     (cur),
        .op_valid(op_valid),
        .step_hit(step_hit),
        .nxt     (nxt)
    );

    lock_state_reg u_reg (
        .clk  (clk),
        .rst_n(rst_n),
        .nxt  (nxt),
        .cur  (cur)
    );

    // Decode outputs from the current state only.
    always_comb begin
        lock_open  = (cur == LK_OPEN);
        state_code = cur;
    end

    // R2: no valid op, no state change.
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(state_code));

    // R3: first step from idle advances.
    p_first_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && state_code == 2'b00 && op_dir == KEY_DIRS[0] && op_dial == FIRST_VAL)
        |=> state_code == 2'b01);

    // R6: a token that matches no step sends the lock to idle.
    p_mismatch_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && step_hit == '0) |=> state_code == 2'b00);

    // R8: any valid op while open closes the lock.
    p_relock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && lock_open) |=> !lock_open);

    // R9: out-of-range dial values go to idle.
    p_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_dial > LIMIT) |=> state_code == 2'b00);

    // R5: opening always follows an accepted operation.
    p_open_after_op_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_open) |-> $past(op_valid));
endmodule

// File: tb/sim_dial_sequence_lock.sv
`timescale 1ns/1ps
module sim_dial_sequence_lock;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic       op_dir = 1'b0;
    logic [4:0] op_dial = '0;
    logic       lock_open;
    logic [1:0] state_code;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    int m_state = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    int key_dir [3] = '{0, 1, 0};
    int key_val [3] = '{13, 22, 3};

    dial_sequence_lock u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_dir(op_dir),
        .op_dial(op_dial), .lock_open(lock_open), .state_code(state_code)
    );

    always #2.5 clk = ~clk;

    // Reference model: count how many ordered tokens have been matched.
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) m_state = 0;
        else if (op_valid) begin
            if (m_state < 3 && int'(op_dir) == key_dir[m_state]
                && int'(op_dial) == key_val[m_state])
                m_state = m_state + 1;
            else if (op_dir == 1'b0 && op_dial == 5'd13)
                m_state = 1;
            else
                m_state = 0;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Compare outputs with the model, then drive the next cycle's inputs.
    task automatic cyc(input bit v, input bit d, input int dial, input string req);
        @(negedge clk);
        check(cur_req, int'(state_code), m_state);
        check("R10", int'(lock_open), (m_state == 3) ? 1 : 0);
        cur_req  = req;
        op_valid = v;
        op_dir   = d;
        op_dial  = 5'(dial);
    endtask

    task automatic op(input bit d, input int dial, input string req);
        cyc(1'b1, d, dial, req);
    endtask

    task automatic open_it(input string req);
        op(0, 13, req); op(1, 22, req); op(0, 3, req);
    endtask

    // Watchdog.
    initial begin
        wait (cycles > 100000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", int'(state_code), 0);
        check("R1", int'(lock_open), 0);
        rst_n = 1'b1;
        // R2: idle cycles with garbage inputs
        cyc(0, 0, 13, "R2");
        cyc(0, 1, 22, "R2");
        // R3, R2 between steps, R4, R5
        op(0, 13, "R3");
        cyc(0, 1, 22, "R2");
        cyc(0, 0, 3, "R2");
        op(1, 22, "R4");
        op(0, 3, "R5");
        cyc(0, 0, 0, "R5");
        check("R5", int'(lock_open), 1);
        cyc(0, 1, 9, "R2");
        // R8: relock to idle and to step one
        op(1, 5, "R8");
        cyc(0, 0, 0, "R8");
        check("R8", int'(state_code), 0);
        open_it("R5");
        op(0, 13, "R8");
        cyc(0, 0, 0, "R8");
        check("R8", int'(state_code), 1);
        // R6: repeated first step holds at step one, wrong value goes idle
        op(0, 13, "R6");
        op(1, 21, "R6");
        op(0, 13, "R6"); op(1, 22, "R6"); op(0, 13, "R6");
        op(1, 22, "R6"); op(0, 4, "R6");
        // R7: wrong direction, permutations
        op(0, 13, "R7"); op(1, 22, "R7"); op(1, 3, "R7");
        op(1, 13, "R7"); op(1, 22, "R7"); op(0, 3, "R7");
        op(1, 22, "R7"); op(0, 13, "R7"); op(0, 3, "R7");
        op(0, 3, "R7"); op(1, 22, "R7"); op(0, 13, "R7");
        op(0, 13, "R7"); op(0, 3, "R7"); op(1, 22, "R7");
        cyc(0, 0, 0, "R7");
        check("R7", int'(lock_open), 0);
        // R9: out-of-range values
        op(0, 13, "R9"); op(1, 30, "R9");
        op(0, 13, "R9"); op(1, 22, "R9"); op(0, 31, "R9");
        cyc(0, 0, 0, "R9");
        check("R9", int'(state_code), 0);
        // R1: reset while open
        open_it("R5");
        cyc(0, 0, 0, "R5");
        rst_n = 1'b0;
        cyc(0, 0, 0, "R1");
        rst_n = 1'b1;
        cyc(0, 0, 0, "R1");
        check("R1", int'(state_code), 0);
        // Mixed traffic biased toward key tokens
        for (int i = 0; i < 400; i++) begin
            int r = int'($urandom_range(0, 9));
            int k = int'($urandom_range(0, 2));
            if (r < 6) op(key_dir[k][0], key_val[k], "R6");
            else if (r < 8) op(1'($urandom_range(0, 1)), int'($urandom_range(0, 31)), "R7");
            else cyc(0, 1'($urandom_range(0, 1)), int'($urandom_range(0, 31)), "R2");
        end
        cyc(0, 0, 0, "R2");
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule